// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block controls a bank of up to 32 general-purpose I/O lines, grouped as four 8-bit ports. Software reaches it through a 32-bit register port. Through that port it sets each line's direction, drives the output latch, reads back the line levels, and programs a 2-bit interrupt mode per line. The mode field selects the edge to watch and also masks the line. Input lines are synchronised. A rising or falling edge that matches the line's mode latches a pending bit in a write-1-to-clear status register.

The pending bits drive a combined interrupt output. When the per-CPU option is built in, a second address window holds one 32-bit enable mask per CPU, and each CPU's interrupt output is gated by its own mask. A build parameter selects one of two layouts:

- **Default layout:** port A sits in the top byte of the one-bit-per-line registers, and the mode fields of ports A/B and C/D swap halves.
- **Reversed layout:** every register is in plain line order.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset, the select, direction, data, status and both mode words read zero. Every per-CPU mask reads 0xFFFFFFFF. `irq_any`, `irq_cpu`, `pin_oe` and `pin_out` are all zero.
- R2: In the direction word (offset 0x08), a 1 makes the line an output and a 0 makes it an input. `pin_oe` follows the direction word and `pin_out` follows the data word written at offset 0x0C. Both are mapped through the byte order of R4.
- R3: A read of offset 0x0C returns the written latch value for output lines. For input lines it returns the pin level after a two-flop synchronizer, so a pin change is visible after the second rising clock edge and not after the first.
- R4: In the one-bit-per-line registers (direction, data, status, CPU masks), line n sits at bit n when `REVERSED`=1. When `REVERSED`=0 it sits at bit 8*(3-n/8)+n%8, which puts port A (lines 0-7) in bits 31:24.
- R5: Line n's 2-bit mode field sits at bit position p = 2*n when `REVERSED`=1, and p = 2*(8*((n/8) XOR 1)+n%8) when `REVERSED`=0. Positions 0-31 are in the word at 0x14, and positions 32-63 are in the word at 0x18 at p-32.
- R6: The mode codes are 00 none, 01 falling edge, 10 rising edge and 11 both edges. A matching edge sets the line's status bit (offset 0x10). The bit reads set after the third rising clock edge following the pin change and is still clear after the second. An edge that does not match the mode sets nothing.
- R7: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A new matching edge in the same cycle as the clear keeps the bit set.
- R8: `irq_any` is high while any status bit is set. `irq_cpu[c]` is high while some set status bit also has its bit set in CPU c's mask.
- R9: With `cpu_win`=1, CPU c's mask is at offset 4*c. It is written and read in the byte order of R4. Offsets of absent CPUs read zero.
- R10: With `cpu_win`=0, offset 0x00 is a 32-bit pin-select word that reads back what was written and has no effect on the pins. Any other unmapped offset reads zero.
- R11: Setting a line's mode to 00 leaves its already pending status bit set. While the mode is 00, no edge on that line sets the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| cpu_win | input | 1 | 0 selects the main registers, 1 selects the per-CPU mask window |
| reg_addr | input | AW | Byte offset within the selected window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| pin_in | input | NLINES | Pin levels |
| pin_out | output | NLINES | Output latch |
| pin_oe | output | NLINES | Output enable per line |
| irq_any | output | 1 | High while any line is pending |
| irq_cpu | output | NCPU | Per-CPU interrupt, gated by that CPU's mask |

## Verification
The edge detector is driven on one line with a rising pulse and a falling pulse under each mode code:

- rising-only and falling-only separate the edge polarity;
- both-edges shows that each polarity latches;
- mode 00 shows the mask.

The same physical words are written to a default-layout and a reversed-layout instance, and the outputs are compared. This tells the two byte orders apart, and two lines (3 and 16) tell the two mode words and the swapped halves apart. A clear write timed to land on the cycle of a new edge separates "new edge wins" from a plain clear. A cleared bit in one CPU mask separates the per-CPU outputs from the combined one.

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int NLINES   = 32,
  parameter bit REVERSED = 1'b0,
  parameter int NCPU     = 2,
  parameter bit PERCPU   = 1'b1,
  parameter int AW       = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              cpu_win,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NLINES-1:0] pin_in,
  output logic [NLINES-1:0] pin_out,
  output logic [NLINES-1:0] pin_oe,
  output logic              irq_any,
  output logic [NCPU-1:0]   irq_cpu
);
  localparam logic [31:0] LMASK = 32'hFFFF_FFFF >> (32 - NLINES);

  function automatic logic [31:0] swz(input logic [31:0] v);
    swz = REVERSED ? v : {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  logic [31:0] sel_q, dir_q, out_q, st_q;
  logic [63:0] mode_q;
  logic [31:0] s1, s2, s3;
  logic [31:0] rise, fall, hit, line_en, wr_clr, dval;
  logic [31:0] mask_q [NCPU];

  wire wr_main = reg_we && !cpu_win;
  wire wr_sel  = wr_main && reg_addr == AW'('h00);
  wire wr_dir  = wr_main && reg_addr == AW'('h08);
  wire wr_dat  = wr_main && reg_addr == AW'('h0C);
  wire wr_st   = wr_main && reg_addr == AW'('h10);
  wire wr_m0   = wr_main && reg_addr == AW'('h14);
  wire wr_m1   = wr_main && reg_addr == AW'('h18);

  assign rise   = s2 & ~s3;
  assign fall   = ~s2 & s3;
  assign wr_clr = wr_st ? swz(reg_wdata) : '0;
  assign dval   = (dir_q & out_q) | (~dir_q & s2);

  for (genvar n = 0; n < 32; n++) begin : g_line
    localparam int F = REVERSED ? n : ((((n / 8) ^ 1) * 8) + (n % 8));
    assign hit[n]     = (mode_q[2*F+1] & rise[n]) | (mode_q[2*F] & fall[n]);
    assign line_en[n] = |mode_q[2*F +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q  <= '0;
      dir_q  <= '0;
      out_q  <= '0;
      st_q   <= '0;
      mode_q <= '0;
      s1     <= '0;
      s2     <= '0;
      s3     <= '0;
    end else begin
      s1 <= 32'(pin_in);
      s2 <= s1;
      s3 <= s2;
      st_q <= ((st_q & ~wr_clr) | hit) & LMASK;
      if (wr_sel) sel_q <= reg_wdata;
      if (wr_dir) dir_q <= swz(reg_wdata) & LMASK;
      if (wr_dat) out_q <= swz(reg_wdata) & LMASK;
      if (wr_m0)  mode_q[31:0]  <= reg_wdata;
      if (wr_m1)  mode_q[63:32] <= reg_wdata;
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    if (PERCPU) begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n)
          mask_q[c] <= LMASK;
        else if (reg_we && cpu_win && reg_addr == AW'(4 * c))
          mask_q[c] <= swz(reg_wdata) & LMASK;
      end
    end else begin : g_fix
      assign mask_q[c] = LMASK;
    end
    assign irq_cpu[c] = |(st_q & mask_q[c]);
  end

  always_comb begin
    reg_rdata = '0;
    if (cpu_win) begin
      for (int c = 0; c < NCPU; c++)
        if (PERCPU && reg_addr == AW'(4 * c)) reg_rdata = swz(mask_q[c]);
    end else begin
      case (reg_addr)
        AW'('h00): reg_rdata = sel_q;
        AW'('h08): reg_rdata = swz(dir_q);
        AW'('h0C): reg_rdata = swz(dval);
        AW'('h10): reg_rdata = swz(st_q);
        AW'('h14): reg_rdata = mode_q[31:0];
        AW'('h18): reg_rdata = mode_q[63:32];
        default:   reg_rdata = '0;
      endcase
    end
  end

  assign irq_any = |st_q;
  assign pin_out = out_q[NLINES-1:0];
  assign pin_oe  = dir_q[NLINES-1:0];
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk #(
  parameter int NLINES = 32,
  parameter int NCPU   = 2,
  parameter int AW     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic              cpu_win,
  input logic [AW-1:0]     reg_addr,
  input logic [31:0]       st_q,
  input logic [31:0]       line_en,
  input logic [NLINES-1:0] pin_oe,
  input logic              irq_any,
  input logic [NCPU-1:0]   irq_cpu
);
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pin_oe == '0 && !irq_any && irq_cpu == '0));

  assert_status_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(reg_we && !cpu_win && reg_addr == AW'('h10)) |-> ((st_q & $past(st_q)) == $past(st_q)));

  assert_cpu_implies_any_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_cpu != '0) |-> irq_any);

  assert_quiet_status_no_cpu_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == '0) |-> (irq_cpu == '0));

  assert_masked_no_new_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(line_en)) == '0));
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.NLINES(NLINES), .NCPU(NCPU), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .cpu_win(cpu_win), .reg_addr(reg_addr),
  .st_q(st_q), .line_en(line_en), .pin_oe(pin_oe), .irq_any(irq_any), .irq_cpu(irq_cpu)
);

// File: tb/gpio_edge_bank_bench.sv
`timescale 1ns/1ps
module gpio_edge_bank_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, reg_we = 1'b0, cpu_win = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, pin_in = '0;
  logic [31:0] rdata, pin_out, pin_oe, rdata_r, pin_out_r, pin_oe_r;
  logic        irq_any, irq_any_r;
  logic [1:0]  irq_cpu, irq_cpu_r;

  gpio_edge_bank #(.REVERSED(1'b0)) u_gpio_edge_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .cpu_win(cpu_win), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .pin_oe(pin_oe), .irq_any(irq_any), .irq_cpu(irq_cpu));

  gpio_edge_bank #(.REVERSED(1'b1)) u_gpio_edge_bank_rev (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .cpu_win(cpu_win), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(rdata_r), .pin_in(pin_in), .pin_out(pin_out_r),
    .pin_oe(pin_oe_r), .irq_any(irq_any_r), .irq_cpu(irq_cpu_r));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata;
        1: act = {30'd0, irq_cpu};
        2: act = {31'd0, irq_any};
        3: act = pin_oe;
        4: act = pin_out;
        5: act = rdata_r;
        6: act = pin_oe_r;
        default: act = pin_out_r;
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  function automatic logic [31:0] bs(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic steps(int n);
    repeat (n) step();
  endtask

  task automatic ex(int k, logic [31:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic rd(bit w, logic [4:0] a, logic [31:0] e, string tag);
    cpu_win = w; reg_addr = a;
    ex(0, e, tag);
  endtask

  task automatic wr(bit w, logic [4:0] a, logic [31:0] d);
    step();
    cpu_win = w; reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    step();
    reg_we = 1'b0;
  endtask

  task automatic pin(logic [31:0] v);
    step();
    pin_in = v;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    steps(4);
    rst_n = 1'b1;

    // R1 reset state
    rd(0, 5'h00, 32'h0, "R1 select");
    rd(0, 5'h08, 32'h0, "R1 direction");
    rd(0, 5'h0C, 32'h0, "R1 data");
    rd(0, 5'h10, 32'h0, "R1 status");
    rd(0, 5'h14, 32'h0, "R1 mode word0");
    rd(0, 5'h18, 32'h0, "R1 mode word1");
    rd(1, 5'h00, 32'hFFFF_FFFF, "R1 cpu0 mask");
    rd(1, 5'h04, 32'hFFFF_FFFF, "R1 cpu1 mask");
    ex(2, 32'h0, "R1 irq_any");
    ex(1, 32'h0, "R1 irq_cpu");
    ex(3, 32'h0, "R1 pin_oe");
    ex(4, 32'h0, "R1 pin_out");

    // R10 unmapped and select; R9 absent cpu
    rd(0, 5'h04, 32'h0, "R10 offset 0x04 unmapped");
    rd(0, 5'h1C, 32'h0, "R10 offset 0x1C unmapped");
    rd(1, 5'h08, 32'h0, "R9 absent cpu2 mask");
    wr(0, 5'h00, 32'hA5A5_A5A5);
    rd(0, 5'h00, 32'hA5A5_A5A5, "R10 select readback");
    ex(3, 32'h0, "R10 select leaves pin_oe");

    // R2 R4 direction and output latch
    wr(0, 5'h08, 32'h0000_00FF);
    ex(3, 32'hFF00_0000, "R2 R4 pin_oe default order");
    ex(6, 32'h0000_00FF, "R4 pin_oe reversed order");
    rd(0, 5'h08, 32'h0000_00FF, "R2 direction readback");
    wr(0, 5'h0C, 32'h0000_005A);
    ex(4, 32'h5A00_0000, "R2 R4 pin_out default order");
    ex(7, 32'h0000_005A, "R4 pin_out reversed order");
    rd(0, 5'h0C, 32'h0000_005A, "R3 data read of output lines");

    // R3 input synchronizer latency
    pin(32'h0001_0000);
    step();
    rd(0, 5'h0C, 32'h0000_005A, "R3 input not visible after one edge");
    step();
    rd(0, 5'h0C, 32'h0000_015A, "R3 input visible after two edges");
    ex(5, 32'h0001_005A, "R4 data read reversed order");
    pin(32'h0);
    steps(3);

    // R5 R6 rising mode on line 16 (field bit 48 -> word1 bit16)
    wr(0, 5'h18, 32'h0002_0000);
    rd(0, 5'h18, 32'h0002_0000, "R5 mode word1 readback");
    pin(32'h0001_0000);
    steps(2);
    rd(0, 5'h10, 32'h0, "R6 status clear after two edges");
    step();
    rd(0, 5'h10, bs(32'h0001_0000), "R6 rising latched after three edges");
    ex(2, 32'h1, "R8 irq_any with pending line");
    ex(1, 32'h3, "R8 both cpu outputs with full masks");

    // R7 write-1-to-clear
    wr(0, 5'h10, ~bs(32'h0001_0000));
    rd(0, 5'h10, bs(32'h0001_0000), "R7 zero bit leaves status");
    wr(0, 5'h10, bs(32'h0001_0000));
    rd(0, 5'h10, 32'h0, "R7 one bit clears status");
    ex(2, 32'h0, "R8 irq_any drops after clear");

    // R6 polarity
    pin(32'h0);
    steps(3);
    rd(0, 5'h10, 32'h0, "R6 falling ignored in rising mode");
    wr(0, 5'h18, 32'h0001_0000);
    pin(32'h0001_0000);
    steps(3);
    rd(0, 5'h10, 32'h0, "R6 rising ignored in falling mode");
    pin(32'h0);
    steps(3);
    rd(0, 5'h10, bs(32'h0001_0000), "R6 falling latched");

    // R9 per-cpu mask
    wr(1, 5'h04, ~bs(32'h0001_0000));
    rd(1, 5'h04, ~bs(32'h0001_0000), "R9 cpu1 mask readback");
    ex(1, 32'h1, "R9 cpu1 gated off by mask");
    ex(2, 32'h1, "R8 irq_any ignores cpu masks");
    wr(1, 5'h04, 32'hFFFF_FFFF);
    wr(0, 5'h10, bs(32'h0001_0000));
    rd(0, 5'h10, 32'h0, "R7 clear after mask test");

    // R6 both edges
    wr(0, 5'h18, 32'h0003_0000);
    pin(32'h0001_0000);
    steps(3);
    rd(0, 5'h10, bs(32'h0001_0000), "R6 both mode rising");
    wr(0, 5'h10, bs(32'h0001_0000));
    pin(32'h0);
    steps(3);
    rd(0, 5'h10, bs(32'h0001_0000), "R6 both mode falling");

    // R7 new edge coinciding with clear
    pin(32'h0001_0000);
    step();
    wr(0, 5'h10, bs(32'h0001_0000));
    rd(0, 5'h10, bs(32'h0001_0000), "R7 edge in clear cycle keeps bit");
    wr(0, 5'h10, bs(32'h0001_0000));
    rd(0, 5'h10, 32'h0, "R7 plain clear");

    // R11 mode 00 masks new edges, keeps pending
    pin(32'h0);
    steps(3);
    wr(0, 5'h18, 32'h0);
    rd(0, 5'h10, bs(32'h0001_0000), "R11 pending kept when masked");
    wr(0, 5'h10, bs(32'h0001_0000));
    pin(32'h0001_0000);
    steps(3);
    rd(0, 5'h10, 32'h0, "R11 masked rise sets nothing");
    pin(32'h0);
    steps(3);
    rd(0, 5'h10, 32'h0, "R11 masked fall sets nothing");

    // R5 R4 line 3: field bit 22 of word0, status bit 27
    wr(0, 5'h14, 32'h00C0_0000);
    rd(0, 5'h14, 32'h00C0_0000, "R5 mode word0 readback");
    pin(32'h0000_0008);
    steps(3);
    rd(0, 5'h10, 32'h0800_0000, "R5 R4 line 3 field and status bit");
    ex(1, 32'h3, "R8 cpu outputs for line 3");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule